// File: doc/BRIEF.md
# Parallel interface interrupt flag and control-line unit

This block holds the interrupt side of a 6522-style parallel interface adapter. Four external control lines are watched: two for port A (`ctl_a1`, `ctl_a2`) and two for port B (`ctl_b1`, `ctl_b2`). Each line keeps its last sampled level. A line sets its flag only when its level changes in the direction that the control register selects. Three single-cycle pulse inputs set their flags directly, with no edge qualification: one from the shift-register section and two from the timers.

Software reaches the block through a 4-bit register index, with separate read and write strobes. It sees the two port output registers and their direction masks, the line control register, the flag register and the enable register. Reads or writes of a port register acknowledge that port's line flags. The second line of each port can be set to an independent mode, in which such accesses leave its flag alone. A single active-high `irq` output reports whether any enabled flag is pending.

Top module: `via_irq_ctrl`

## Requirements
- R1: Register indices are: port B data 0, port A data 1, port B direction 2, port A direction 3, line control 12, flag register 13, enable register 14, and port A data without handshake 15. The indices 4 to 11 read as 0 and ignore writes. `rd_data` shows the addressed register combinationally, whether or not `rd_en` is asserted.
- R2: Each control line stores its last sampled level. A flag is set only at a clock edge where the sampled level differs from the stored level, and only for the selected direction. For `ctl_a1` the direction bit is control bit 0; for `ctl_b1` it is control bit 4. A 1 selects a rising edge and a 0 selects a falling edge.
- R3: `ctl_a2` uses control field [3:1] and `ctl_b2` uses control field [7:5]. The middle bit of each field (bit 2 or bit 6) selects a rising edge when 1 and a falling edge when 0.
- R4: Every cycle in which `sr_set` is high sets flag bit 2, even when it stays high. `t2_set` sets bit 5 and `t1_set` sets bit 6. A set in the same cycle as a clear of the same flag leaves the flag set.
- R5: A read or write at index 0 clears flag bits 4 (`ctl_b1`) and 3 (`ctl_b2`). A read or write at index 1 or 15 clears flag bits 1 (`ctl_a1`) and 0 (`ctl_a2`).
- R6: When a line-2 field holds 001 or 011 (independent mode), port accesses do not clear that line's flag.
- R7: A write to a port data register changes only the bits whose direction bit is 1. The other bits keep their value. `pa_o` and `pb_o` show the port data registers.
- R8: Flag register layout: bit 0 `ctl_a2`, bit 1 `ctl_a1`, bit 2 shift, bit 3 `ctl_b2`, bit 4 `ctl_b1`, bit 5 timer 2, bit 6 timer 1. Bit 7 reads as 1 when any enabled flag is set. Writing a 1 to bits [6:0] clears those flags.
- R9: Writing the enable register with bit 7 set enables the bits written as 1. With bit 7 clear, it disables them. Bit 7 of the enable register always reads as 1.
- R10: `irq` is high exactly when some bit of (flags & enables)[6:0] is set. It follows the flag and enable registers in the same cycle, with no extra register.
- R11: Reset (`rst_n` low) clears every register and every stored line level. After reset, `irq` is 0, the enable register reads 0x80 and the flag register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` |
| ctl_a1 | input | 1 | Port A control line 1 |
| ctl_a2 | input | 1 | Port A control line 2 |
| ctl_b1 | input | 1 | Port B control line 1 |
| ctl_b2 | input | 1 | Port B control line 2 |
| sr_set | input | 1 | Shift-section flag pulse |
| t1_set | input | 1 | Timer 1 flag pulse |
| t2_set | input | 1 | Timer 2 flag pulse |
| pa_o | output | 8 | Port A data register |
| pb_o | output | 8 | Port B data register |
| irq | output | 1 | Interrupt request, active high |

## Verification
A line level, set pulse or register access presented before clock edge k takes effect at edge k. Its effect on the flag register, `rd_data` and `irq` is therefore visible right after that same edge, with no further delay. The bench drives stimulus on a falling edge, lets one rising edge pass, and drops the strobes on the next falling edge. It then points the index at the flag register and compares both `rd_data` and `irq` in that half cycle. A peek with `rd_en` low is free of side effects, so the bench can look at the ports and registers without acknowledging anything.

// File: rtl/via_pkg.sv
package via_pkg;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int NFLAG = 7;

    localparam logic [AW-1:0] IDX_PB     = 4'd0;
    localparam logic [AW-1:0] IDX_PA     = 4'd1;
    localparam logic [AW-1:0] IDX_DIRB   = 4'd2;
    localparam logic [AW-1:0] IDX_DIRA   = 4'd3;
    localparam logic [AW-1:0] IDX_LCTL   = 4'd12;
    localparam logic [AW-1:0] IDX_FLAG   = 4'd13;
    localparam logic [AW-1:0] IDX_ENA    = 4'd14;
    localparam logic [AW-1:0] IDX_PA_NH  = 4'd15;

    localparam int F_A2 = 0;
    localparam int F_A1 = 1;
    localparam int F_SH = 2;
    localparam int F_B2 = 3;
    localparam int F_B1 = 4;
    localparam int F_T2 = 5;
    localparam int F_T1 = 6;

    // line order inside the edge array
    localparam int L_A1 = 0;
    localparam int L_A2 = 1;
    localparam int L_B1 = 2;
    localparam int L_B2 = 3;
    localparam int NLINE = 4;

    typedef struct packed {
        logic [NFLAG-1:0] flag;
        logic [NFLAG-1:0] ena;
        logic [DW-1:0]    lctl;
    } irq_state_t;
endpackage

// File: rtl/via_line_edge.sv
module via_line_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic hit
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = level;
        hit   = (level != lvl_q) && (level == rise_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    // R2
    r2_no_hit_without_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == lvl_q) |-> !hit);
endmodule

// File: rtl/via_port_reg.sv
module via_port_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         dir_we,
    input  logic         dat_we,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dat_q
);
    logic [W-1:0] dir_d, dat_d;

    always_comb begin
        dir_d = dir_q;
        dat_d = dat_q;
        if (dir_we) dir_d = wdata;
        if (dat_we) dat_d = (dat_q & ~dir_q) | (wdata & dir_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            dir_q <= dir_d;
            dat_q <= dat_d;
        end
    end

    // R7
    r7_input_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (((dat_q ^ $past(dat_q)) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/via_irq_ctrl.sv
module via_irq_ctrl
    import via_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          ctl_a1,
    input  logic          ctl_a2,
    input  logic          ctl_b1,
    input  logic          ctl_b2,
    input  logic          sr_set,
    input  logic          t1_set,
    input  logic          t2_set,
    output logic [DW-1:0] pa_o,
    output logic [DW-1:0] pb_o,
    output logic          irq
);
    irq_state_t st_d, st_q;

    logic [NLINE-1:0] line_lvl, line_rise, line_hit;
    logic [DW-1:0]    dira_q, dirb_q;
    logic             acc_a, acc_b, a2_indep, b2_indep, any_pend;
    logic [NFLAG-1:0] set_vec;

    assign line_lvl = {ctl_b2, ctl_b1, ctl_a2, ctl_a1};
    assign line_rise[L_A1] = st_q.lctl[0];
    assign line_rise[L_A2] = st_q.lctl[2];
    assign line_rise[L_B1] = st_q.lctl[4];
    assign line_rise[L_B2] = st_q.lctl[6];

    generate
        for (genvar g = 0; g < NLINE; g++) begin : g_line
            via_line_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .level    (line_lvl[g]),
                .rise_sel (line_rise[g]),
                .hit      (line_hit[g])
            );
        end
    endgenerate

    via_port_reg #(.W(DW)) u_port_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (wr_data),
        .dir_we (wr_en && reg_addr == IDX_DIRA),
        .dat_we (wr_en && (reg_addr == IDX_PA || reg_addr == IDX_PA_NH)),
        .dir_q  (dira_q),
        .dat_q  (pa_o)
    );

    via_port_reg #(.W(DW)) u_port_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (wr_data),
        .dir_we (wr_en && reg_addr == IDX_DIRB),
        .dat_we (wr_en && reg_addr == IDX_PB),
        .dir_q  (dirb_q),
        .dat_q  (pb_o)
    );

    always_comb begin
        acc_a    = (wr_en || rd_en) && (reg_addr == IDX_PA || reg_addr == IDX_PA_NH);
        acc_b    = (wr_en || rd_en) && (reg_addr == IDX_PB);
        a2_indep = st_q.lctl[1] && !st_q.lctl[3];
        b2_indep = st_q.lctl[5] && !st_q.lctl[7];

        set_vec        = '0;
        set_vec[F_A2]  = line_hit[L_A2];
        set_vec[F_A1]  = line_hit[L_A1];
        set_vec[F_SH]  = sr_set;
        set_vec[F_B2]  = line_hit[L_B2];
        set_vec[F_B1]  = line_hit[L_B1];
        set_vec[F_T2]  = t2_set;
        set_vec[F_T1]  = t1_set;

        st_d = st_q;
        if (acc_a) begin
            st_d.flag[F_A1] = 1'b0;
            if (!a2_indep) st_d.flag[F_A2] = 1'b0;
        end
        if (acc_b) begin
            st_d.flag[F_B1] = 1'b0;
            if (!b2_indep) st_d.flag[F_B2] = 1'b0;
        end
        if (wr_en && reg_addr == IDX_FLAG)
            st_d.flag = st_d.flag & ~wr_data[NFLAG-1:0];
        st_d.flag = st_d.flag | set_vec;

        if (wr_en && reg_addr == IDX_ENA) begin
            if (wr_data[DW-1]) st_d.ena = st_q.ena | wr_data[NFLAG-1:0];
            else               st_d.ena = st_q.ena & ~wr_data[NFLAG-1:0];
        end
        if (wr_en && reg_addr == IDX_LCTL)
            st_d.lctl = wr_data;

        any_pend = |(st_q.flag & st_q.ena);
        irq      = any_pend;

        case (reg_addr)
            IDX_PB:              rd_data = pb_o;
            IDX_PA, IDX_PA_NH:   rd_data = pa_o;
            IDX_DIRB:            rd_data = dirb_q;
            IDX_DIRA:            rd_data = dira_q;
            IDX_LCTL:            rd_data = st_q.lctl;
            IDX_FLAG:            rd_data = {any_pend, st_q.flag};
            IDX_ENA:             rd_data = {1'b1, st_q.ena};
            default:             rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    r4_shift_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_set |=> st_q.flag[F_SH]);
    // R5
    r5_b1_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == IDX_PB && !line_hit[L_B1]) |=> !st_q.flag[F_B1]);
    // R9
    r9_enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == IDX_ENA && wr_data[DW-1])
        |=> ((st_q.ena & $past(wr_data[NFLAG-1:0])) == $past(wr_data[NFLAG-1:0])));
    // R8
    r8_summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IDX_FLAG) |-> (rd_data[DW-1] == irq));
endmodule

// File: tb/tb_via_irq_ctrl.sv
module tb_via_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ctl_a1 = 1'b0, ctl_a2 = 1'b0, ctl_b1 = 1'b0, ctl_b2 = 1'b0;
    logic       sr_set = 1'b0, t1_set = 1'b0, t2_set = 1'b0;
    logic [7:0] pa_o, pb_o;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    via_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ctl_a1(ctl_a1), .ctl_a2(ctl_a2),
        .ctl_b1(ctl_b1), .ctl_b2(ctl_b2), .sr_set(sr_set), .t1_set(t1_set),
        .t2_set(t2_set), .pa_o(pa_o), .pb_o(pb_o), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] addr;
        logic       wr;
        logic       rd;
        logic [7:0] wd;
        logic [3:0] lines;   // {a1, a2, b1, b2}
        logic       sr;
        logic [7:0] exp_flag;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd14, 1'b1, 1'b0, 8'h9F, 4'b0000, 1'b0, 8'h00, 1'b0}, // R9 enable bits 0..4
        '{4'd12, 1'b1, 1'b0, 8'h00, 4'b0000, 1'b0, 8'h00, 1'b0}, // all falling
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b1000, 1'b0, 8'h00, 1'b0}, // R2 wrong edge
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 8'h82, 1'b1}, // R2 falling a1
        '{4'd1,  1'b0, 1'b1, 8'h00, 4'b0000, 1'b0, 8'h00, 1'b0}, // R5 read port A
        '{4'd12, 1'b1, 1'b0, 8'h55, 4'b0000, 1'b0, 8'h00, 1'b0}, // all rising
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b1111, 1'b0, 8'h9B, 1'b1}, // R2 R3 rising
        '{4'd0,  1'b0, 1'b1, 8'h00, 4'b1111, 1'b0, 8'h83, 1'b1}, // R5 read port B
        '{4'd15, 1'b0, 1'b1, 8'h00, 4'b1111, 1'b0, 8'h00, 1'b0}, // R5 index 15
        '{4'd12, 1'b1, 1'b0, 8'h22, 4'b1111, 1'b0, 8'h00, 1'b0}, // falling, line2 indep
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 8'h9B, 1'b1}, // R3 falling
        '{4'd1,  1'b1, 1'b0, 8'h00, 4'b0000, 1'b0, 8'h99, 1'b1}, // R6 a2 kept
        '{4'd0,  1'b0, 1'b1, 8'h00, 4'b0000, 1'b0, 8'h89, 1'b1}, // R6 b2 kept
        '{4'd13, 1'b1, 1'b0, 8'h09, 4'b0000, 1'b0, 8'h00, 1'b0}, // R8 write-1-clear
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b0000, 1'b1, 8'h84, 1'b1}, // R4 shift pulse
        '{4'd13, 1'b1, 1'b0, 8'h04, 4'b0000, 1'b0, 8'h00, 1'b0}, // R8 clear
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b0000, 1'b1, 8'h84, 1'b1}, // R4 again
        '{4'd13, 1'b1, 1'b0, 8'h04, 4'b0000, 1'b1, 8'h84, 1'b1}, // R4 set beats clear
        '{4'd14, 1'b1, 1'b0, 8'h04, 4'b0000, 1'b0, 8'h04, 1'b0}, // R9 R10 disable
        '{4'd14, 1'b1, 1'b0, 8'h84, 4'b0000, 1'b0, 8'h84, 1'b1}, // R9 R10 enable
        '{4'd13, 1'b1, 1'b0, 8'h7F, 4'b0000, 1'b0, 8'h00, 1'b0}, // R8 clear all
        '{4'd0,  1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 8'h00, 1'b0}  // R2 steady level
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.5;
        v = rd_data;
    endtask

    // called at a falling edge; returns at a falling edge with strobes dropped
    task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d);
        reg_addr = a; wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; sr_set = 1'b0; t1_set = 1'b0; t2_set = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        peek(4'd13, v); chk("R11 flag after reset", v, 8'h00);
        peek(4'd14, v); chk("R11 enable after reset", v, 8'h80);
        chk("R11 irq after reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {ctl_a1, ctl_a2, ctl_b1, ctl_b2} = VEC[i].lines;
            sr_set = VEC[i].sr;
            cyc(VEC[i].addr, VEC[i].wr, VEC[i].rd, VEC[i].wd);
            peek(4'd13, v);
            chk($sformatf("R2-table step %0d flag", i), v, VEC[i].exp_flag);
            chk($sformatf("R10 step %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].exp_irq});
        end

        // R7 direction mask on port A
        cyc(4'd3, 1'b1, 1'b0, 8'h0F);
        cyc(4'd1, 1'b1, 1'b0, 8'hFF);
        chk("R7 port A low nibble out", pa_o, 8'h0F);
        cyc(4'd3, 1'b1, 1'b0, 8'hF0);
        cyc(4'd15, 1'b1, 1'b0, 8'hA5);
        chk("R7 port A inputs kept", pa_o, 8'hAF);
        peek(4'd15, v); chk("R1 port A via index 15", v, 8'hAF);
        peek(4'd3, v);  chk("R1 port A direction", v, 8'hF0);
        cyc(4'd2, 1'b1, 1'b0, 8'hFF);
        cyc(4'd0, 1'b1, 1'b0, 8'h3C);
        chk("R7 port B full output", pb_o, 8'h3C);
        peek(4'd0, v); chk("R1 port B read", v, 8'h3C);

        // R1 unused index ignores writes
        cyc(4'd11, 1'b1, 1'b0, 8'hFF);
        peek(4'd11, v); chk("R1 unused index reads 0", v, 8'h00);
        peek(4'd12, v); chk("R1 control unchanged", v, 8'h22);

        // R4 timer flags; R10 disabled flag leaves irq low
        t1_set = 1'b1;
        cyc(4'd0, 1'b0, 1'b0, 8'h00);
        peek(4'd13, v); chk("R4 timer1 flag", v, 8'h40);
        chk("R10 disabled flag no irq", {7'd0, irq}, 8'h00);
        t2_set = 1'b1;
        cyc(4'd0, 1'b0, 1'b0, 8'h00);
        peek(4'd13, v); chk("R4 timer2 flag", v, 8'h60);

        // R11 reset mid-run
        sr_set = 1'b1;
        cyc(4'd0, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b0;
        #0.5;
        peek(4'd13, v); chk("R11 flag cleared", v, 8'h00);
        peek(4'd14, v); chk("R11 enable cleared", v, 8'h80);
        chk("R11 port A cleared", pa_o, 8'h00);
        chk("R11 irq low", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule